// File: doc/BRIEF.md
# Bridge Target Address Decoder

This block classifies each request crossing an I/O hub bridge and picks where it goes. A request carries a 64-bit address, a kind (memory, I/O, configuration), a side flag (host link or PCI Express) and a debug flag. The block first checks the address against the legal range for its kind and side. For memory, it then applies per-region access attributes in the legacy area below 1 MB. Next it compares the address with programmable memory and I/O windows, one pair per downstream port. A request that nothing claims falls through to the subtractive-decode (legacy) port.

Requests enter through a valid/ready handshake and pass through two register stages. Results leave in the same order as the requests, with one result per accepted request. Each result raises exactly one of four flags: error, attribute abort, port hit (with a port index) or subtractive. Window, top-of-memory and attribute settings are plain inputs that are held steady while traffic flows.

Top module: `hub_addr_decoder`

## Requirements
- R1: A memory request hits a port window only when address bits 63:36 are all zero. A host-side memory request with any of those bits set is routed subtractively, not flagged as an error.
- R2: A memory request from PCIe whose address is greater than or equal to `mem_top` raises the error flag. `mem_top` is an exclusive bound of at most 2^40.
- R3: For host-side I/O requests only bits 15:0 are decoded. Bits 63:16 never cause an error and never change the routing.
- R4: A PCIe I/O request with any of bits 31:16 set raises the error flag. Bits 63:32 are not examined.
- R5: A configuration request is laid out as bus 27:20, device 19:15, function 14:12 and register 11:0. If any of bits 63:28 (the segment) is set, the error flag is raised; otherwise the request is routed subtractively. Kind code 2'b11 is reserved and always raises the error flag. Kind codes: 00 memory, 01 I/O, 10 configuration.
- R6: A memory address in 0xC0000..0xFFFFF falls in legacy region n = (address − 0xC0000)/16 KB. That region's attribute is `leg_attr[2n+1:2n]`: 00 disabled, 01 read only, 10 write only, 11 read/write.
- R7: A legacy access that is disabled, a write to a read-only region, or a read of a write-only region raises the abort flag. A permitted legacy access continues to window decode.
- R8: Port p claims a memory request when `mem_base[p] <= addr[35:20] <= mem_limit[p]`, in 1 MB units. It claims an I/O request when `io_base[p] <= addr[15:12] <= io_limit[p]`, in 4 KB units. A base above the limit disables that window.
- R9: When several windows match, the lowest port index is reported.
- R10: A request with no error, no abort and no window match raises the subtractive flag, with `res_port` = 0.
- R11: The priority order is error, then abort, then port hit, then subtractive, and every result raises exactly one of these flags.
- R12: For host-side requests with the debug flag set, address bits 63:40 are cleared before decode. PCIe requests ignore the debug flag.
- R13: An accepted request yields its result two clock edges later when `res_ready` is high. Results keep request order. While `res_ready` is low, the result stays stable, and with both stages full `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when valid |
| req_addr | input | 64 | Request address |
| req_kind | input | 2 | 00 memory, 01 I/O, 10 configuration, 11 reserved |
| req_from_pcie | input | 1 | 1 = request arrived from PCIe, 0 = from host link |
| req_write | input | 1 | 1 = write access |
| req_debug | input | 1 | Debug header mode (host side only) |
| mem_top | input | 41 | Exclusive top of PCIe memory space |
| mem_base | input | 4×16 | Per-port memory window base, 1 MB units |
| mem_limit | input | 4×16 | Per-port memory window limit, 1 MB units |
| io_base | input | 4×4 | Per-port I/O window base, 4 KB units |
| io_limit | input | 4×4 | Per-port I/O window limit, 4 KB units |
| leg_attr | input | 32 | Two attribute bits per legacy region |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumed this edge when valid |
| res_port | output | 2 | Claiming port (0 unless hit) |
| res_hit | output | 1 | A port window claimed the request |
| res_sub | output | 1 | Routed to subtractive port |
| res_err | output | 1 | Range or segment error |
| res_abort | output | 1 | Legacy attribute violation |

## Verification
The bench builds the block with its default parameters: four ports, a 36-bit host space, 16 legacy regions and a debug mask over bits 63:40. It uses a fixed window set with overlapping, boundary and disabled windows, and sets each region's attribute to its index mod 4, so all four attribute codes appear. It sweeps 32 address patterns against every kind, side, access direction and debug setting. Directed cases then lower `mem_top` into the legacy area and add a window that covers the legacy area, which exposes the error-over-abort and abort-over-hit orderings. A stalled-output sequence checks back-pressure and ordering.

// File: rtl/hub_dec_pkg.sv
package hub_dec_pkg;

  typedef enum logic [1:0] {
    K_MEM = 2'b00,
    K_IO  = 2'b01,
    K_CFG = 2'b10,
    K_RSV = 2'b11
  } req_kind_e;

  typedef enum logic [1:0] {
    A_OFF = 2'b00,
    A_RO  = 2'b01,
    A_WO  = 2'b10,
    A_RW  = 2'b11
  } leg_attr_e;

  typedef struct packed {
    logic [63:0] addr;
    req_kind_e   kind;
    logic        from_pcie;
    logic        wr;
  } req_t;

  // Access permission for one legacy region attribute.
  function automatic logic attr_permits(input leg_attr_e a, input logic wr);
    case (a)
      A_RW:    attr_permits = 1'b1;
      A_RO:    attr_permits = !wr;
      A_WO:    attr_permits = wr;
      default: attr_permits = 1'b0;
    endcase
  endfunction

  // Address after the debug-mode source bits are stripped (host side only).
  function automatic logic [63:0] strip_debug(input logic [63:0] a, input logic [63:0] mask,
                                              input logic dbg, input logic from_pcie);
    strip_debug = (dbg && !from_pcie) ? (a & ~mask) : a;
  endfunction

endpackage

// File: rtl/hub_dec_check.sv
module hub_dec_check
  import hub_dec_pkg::*;
#(
  parameter int TOP_W        = 41,
  parameter int IO_BITS      = 16,
  parameter int PCIE_IO_BITS = 32,
  parameter int CFG_BITS     = 28,
  parameter int LEG_IDX_W    = 4,
  parameter int LEG_REG_BITS = 14,
  localparam int LEG_N       = 1 << LEG_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_en,
  input  logic [63:0]          addr,
  input  req_kind_e            kind,
  input  logic                 from_pcie,
  input  logic                 wr,
  input  logic [TOP_W-1:0]     mem_top,
  input  logic [2*LEG_N-1:0]   leg_attr,
  output logic                 err,
  output logic                 abort
);
  localparam int LEG_BASE_BITS = LEG_REG_BITS + LEG_IDX_W;
  localparam int ONE_MB_BITS   = 20;

  logic                 mem_over, io_over, cfg_bad, in_leg, leg_ok;
  logic [LEG_IDX_W-1:0] leg_idx;
  leg_attr_e            leg_a;

  assign mem_over = from_pcie && (addr >= {{(64-TOP_W){1'b0}}, mem_top});
  assign io_over  = from_pcie && (|addr[PCIE_IO_BITS-1:IO_BITS]);
  assign cfg_bad  = |addr[63:CFG_BITS];

  assign in_leg  = (addr[63:ONE_MB_BITS] == '0) && (&addr[ONE_MB_BITS-1:LEG_BASE_BITS]);
  assign leg_idx = addr[LEG_BASE_BITS-1:LEG_REG_BITS];
  assign leg_a   = leg_attr_e'(leg_attr[{leg_idx, 1'b0} +: 2]);
  assign leg_ok  = attr_permits(leg_a, wr);

  always_comb begin
    case (kind)
      K_MEM:   err = mem_over;
      K_IO:    err = io_over;
      K_CFG:   err = cfg_bad;
      default: err = 1'b1;
    endcase
  end

  assign abort = (kind == K_MEM) && in_leg && !leg_ok;

  // R3: host-side I/O never errors, whatever its upper bits
  a_r3_host_io_clean: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && kind == K_IO && !from_pcie |-> !err);
  // R4: PCIe I/O beyond 64 KB errors
  a_r4_pcie_io_range: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && kind == K_IO && from_pcie && (|addr[31:16]) |-> err);
  // R5: a config error always names a nonzero segment
  a_r5_cfg_segment: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && kind == K_CFG && err |-> (|addr[63:CFG_BITS]));
  // R7: an abort only ever comes from the legacy area
  a_r7_abort_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && abort |-> addr < 64'h10_0000 && addr >= 64'hC_0000);

endmodule

// File: rtl/hub_dec_windows.sv
module hub_dec_windows #(
  parameter int NPORT   = 4,
  parameter int MWIN_W  = 16,
  parameter int IOWIN_W = 4,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chk_en,
  input  logic                          is_mem,
  input  logic                          is_io,
  input  logic                          hi_clear,
  input  logic [MWIN_W-1:0]             mem_unit,
  input  logic [IOWIN_W-1:0]            io_unit,
  input  logic [NPORT-1:0][MWIN_W-1:0]  mem_base,
  input  logic [NPORT-1:0][MWIN_W-1:0]  mem_limit,
  input  logic [NPORT-1:0][IOWIN_W-1:0] io_base,
  input  logic [NPORT-1:0][IOWIN_W-1:0] io_limit,
  output logic                          hit,
  output logic [PORT_W-1:0]             port
);
  logic [NPORT-1:0] match;
  logic [NPORT-1:0] below;

  function automatic logic mem_in(input logic [MWIN_W-1:0] lo, input logic [MWIN_W-1:0] hi,
                                  input logic [MWIN_W-1:0] v);
    mem_in = (v >= lo) && (v <= hi);
  endfunction

  function automatic logic io_in(input logic [IOWIN_W-1:0] lo, input logic [IOWIN_W-1:0] hi,
                                 input logic [IOWIN_W-1:0] v);
    io_in = (v >= lo) && (v <= hi);
  endfunction

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign match[p] = (is_mem && hi_clear && mem_in(mem_base[p], mem_limit[p], mem_unit))
                    || (is_io && io_in(io_base[p], io_limit[p], io_unit));
  end

  always_comb begin
    port = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (match[p]) port = PORT_W'(p);
    end
  end

  assign hit   = |match;
  assign below = (NPORT'(1) << port) - NPORT'(1);

  // R9: the reported port matches and no lower port does
  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && hit |-> match[port] && (match & below) == '0);
  // R1: a memory claim needs bits 63:36 clear
  a_r1_claim_low: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && hit && is_mem |-> hi_clear);

endmodule

// File: rtl/hub_addr_decoder.sv
module hub_addr_decoder
  import hub_dec_pkg::*;
#(
  parameter int          NPORT        = 4,
  parameter int          HOST_BITS    = 36,
  parameter int          TOP_W        = 41,
  parameter int          MEM_GRAN     = 20,
  parameter int          IO_BITS      = 16,
  parameter int          IO_GRAN      = 12,
  parameter int          LEG_IDX_W    = 4,
  parameter logic [63:0] DBG_MASK     = 64'hFFFF_FF00_0000_0000,
  localparam int         PORT_W       = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int         MWIN_W       = HOST_BITS - MEM_GRAN,
  localparam int         IOWIN_W      = IO_BITS - IO_GRAN,
  localparam int         LEG_N        = 1 << LEG_IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [63:0]                   req_addr,
  input  logic [1:0]                    req_kind,
  input  logic                          req_from_pcie,
  input  logic                          req_write,
  input  logic                          req_debug,
  input  logic [TOP_W-1:0]              mem_top,
  input  logic [NPORT-1:0][MWIN_W-1:0]  mem_base,
  input  logic [NPORT-1:0][MWIN_W-1:0]  mem_limit,
  input  logic [NPORT-1:0][IOWIN_W-1:0] io_base,
  input  logic [NPORT-1:0][IOWIN_W-1:0] io_limit,
  input  logic [2*LEG_N-1:0]            leg_attr,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [PORT_W-1:0]             res_port,
  output logic                          res_hit,
  output logic                          res_sub,
  output logic                          res_err,
  output logic                          res_abort
);
  // Handshake and stage occupancy
  logic s1_v, s2_v;
  req_t s1_q;
  logic s2_take, s1_move, req_fire;

  assign s2_take   = !s2_v || res_ready;
  assign s1_move   = s1_v && s2_take;
  assign req_ready = !s1_v || s1_move;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      if (req_fire)     s1_v <= 1'b1;
      else if (s1_move) s1_v <= 1'b0;
      if (s1_move)        s2_v <= 1'b1;
      else if (res_ready) s2_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
    end else if (req_fire) begin
      s1_q.addr      <= strip_debug(req_addr, DBG_MASK, req_debug, req_from_pcie);
      s1_q.kind      <= req_kind_e'(req_kind);
      s1_q.from_pcie <= req_from_pcie;
      s1_q.wr        <= req_write;
    end
  end

  // Stage 1 decode
  logic              err_w, abort_w, hit_w;
  logic [PORT_W-1:0] port_w;

  hub_dec_check #(
    .TOP_W(TOP_W), .IO_BITS(IO_BITS), .PCIE_IO_BITS(32), .CFG_BITS(28),
    .LEG_IDX_W(LEG_IDX_W), .LEG_REG_BITS(MEM_GRAN - 2 - LEG_IDX_W)
  ) u_check (
    .clk(clk), .rst_n(rst_n), .chk_en(s1_v),
    .addr(s1_q.addr), .kind(s1_q.kind), .from_pcie(s1_q.from_pcie), .wr(s1_q.wr),
    .mem_top(mem_top), .leg_attr(leg_attr),
    .err(err_w), .abort(abort_w)
  );

  hub_dec_windows #(
    .NPORT(NPORT), .MWIN_W(MWIN_W), .IOWIN_W(IOWIN_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .chk_en(s1_v),
    .is_mem(s1_q.kind == K_MEM), .is_io(s1_q.kind == K_IO),
    .hi_clear(s1_q.addr[63:HOST_BITS] == '0),
    .mem_unit(s1_q.addr[HOST_BITS-1:MEM_GRAN]),
    .io_unit(s1_q.addr[IO_BITS-1:IO_GRAN]),
    .mem_base(mem_base), .mem_limit(mem_limit),
    .io_base(io_base), .io_limit(io_limit),
    .hit(hit_w), .port(port_w)
  );

  // Stage 2: resolve priority and hold the result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_err   <= 1'b0;
      res_abort <= 1'b0;
      res_hit   <= 1'b0;
      res_sub   <= 1'b0;
      res_port  <= '0;
    end else if (s1_move) begin
      res_err   <= err_w;
      res_abort <= !err_w && abort_w;
      res_hit   <= !err_w && !abort_w && hit_w;
      res_sub   <= !err_w && !abort_w && !hit_w;
      res_port  <= (!err_w && !abort_w && hit_w) ? port_w : '0;
    end
  end

  assign res_valid = s2_v;

  // R11: exactly one outcome flag per result
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_err, res_abort, res_hit, res_sub}));
  // R10: a non-hit result reports port 0
  a_r10_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_port == '0);
  // R13: a stalled result is held
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid
      && $stable({res_port, res_err, res_abort, res_hit, res_sub}));
  // R13: a full pipe refuses input
  a_r13_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s2_v && !res_ready |-> !req_ready);
  // R12: PCIe addresses enter unmasked
  a_r12_pcie_raw: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_from_pcie |=> s1_q.addr == $past(req_addr));

endmodule

// File: tb/hub_addr_decoder_tb.sv
module hub_addr_decoder_tb;
  localparam logic [63:0] DBG_BITS = 64'hFFFF_FF00_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [63:0]       req_addr = '0;
  logic [1:0]        req_kind = '0;
  logic              req_from_pcie = 1'b0, req_write = 1'b0, req_debug = 1'b0;
  logic [40:0]       mem_top;
  logic [3:0][15:0]  mem_base, mem_limit;
  logic [3:0][3:0]   io_base, io_limit;
  logic [31:0]       leg_attr;
  logic              res_valid, res_ready = 1'b1;
  logic [1:0]        res_port;
  logic              res_hit, res_sub, res_err, res_abort;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hub_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_from_pcie(req_from_pcie),
    .req_write(req_write), .req_debug(req_debug), .mem_top(mem_top),
    .mem_base(mem_base), .mem_limit(mem_limit), .io_base(io_base), .io_limit(io_limit),
    .leg_attr(leg_attr), .res_valid(res_valid), .res_ready(res_ready),
    .res_port(res_port), .res_hit(res_hit), .res_sub(res_sub),
    .res_err(res_err), .res_abort(res_abort)
  );

  // Expected result packed as {err, abort, hit, sub, port[1:0]}
  function automatic logic [5:0] model(input logic [63:0] a_in, input logic [1:0] k,
                                       input logic pc, input logic wr, input logic dbg);
    logic [63:0] a;
    logic [1:0]  at;
    logic        ok;
    a = (!pc && dbg) ? (a_in & ~DBG_BITS) : a_in;
    if (k == 2'd3) return 6'b100000;
    if (k == 2'd2) return (a >> 28) != 0 ? 6'b100000 : 6'b000100;
    if (k == 2'd1) begin
      if (pc && ((a >> 16) & 64'hFFFF) != 0) return 6'b100000;
      for (int p = 0; p < 4; p++)
        if (((a >> 12) & 64'hF) >= 64'(io_base[p]) && ((a >> 12) & 64'hF) <= 64'(io_limit[p]))
          return {4'b0010, 2'(p)};
      return 6'b000100;
    end
    if (pc && a >= 64'(mem_top)) return 6'b100000;
    if (a >= 64'hC_0000 && a <= 64'hF_FFFF) begin
      at = leg_attr[2 * int'((a - 64'hC_0000) / 64'h4000) +: 2];
      case (at)
        2'b11: ok = 1'b1;
        2'b01: ok = (wr == 1'b0);
        2'b10: ok = (wr == 1'b1);
        default: ok = 1'b0;
      endcase
      if (!ok) return 6'b010000;
    end
    if (a < 64'h10_0000_0000)
      for (int p = 0; p < 4; p++)
        if ((a >> 20) >= 64'(mem_base[p]) && (a >> 20) <= 64'(mem_limit[p]))
          return {4'b0010, 2'(p)};
    return 6'b000100;
  endfunction

  function automatic string tag_of(input logic [5:0] e, input logic [1:0] k, input logic pc);
    if (e[5]) return (k == 2'd0) ? "R2" : (k == 2'd1) ? "R4" : "R5";
    if (e[4]) return "R7";
    if (e[3]) return (k == 2'd1) ? "R8" : "R9";
    if (k == 2'd1 && !pc) return "R3";
    return "R10";
  endfunction

  function automatic logic [63:0] pattern(input int i);
    if (i < 16) return 64'hC_0000 + 64'(i) * 64'h4000 + 64'h10;
    case (i)
      16: return 64'h0;
      17: return 64'h1000_0000;
      18: return 64'h1800_0000;
      19: return 64'h2FF0_0000;
      20: return 64'h3000_0000;
      21: return 64'hF_FFF0_0000;
      22: return 64'hF_FFFF_FFFF;
      23: return 64'h10_0000_0000;
      24: return 64'h3F_FFFF_FFFF;
      25: return 64'h40_0000_0000;
      26: return 64'h100_1000_0000;
      27: return 64'h1_0000_2000;
      28: return 64'h1_2000;
      29: return 64'hF000;
      30: return 64'h8000;
      default: return 64'hFFFF_0000_0FF0_1000;
    endcase
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] observed();
    return {res_err, res_abort, res_hit, res_sub, res_port};
  endfunction

  task automatic send(input logic [63:0] a, input logic [1:0] k, input logic pc,
                      input logic wr, input logic dbg, input string req);
    logic [5:0] e;
    e = model(a, k, pc, wr, dbg);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k;
    req_from_pcie = pc; req_write = wr; req_debug = dbg;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid == 1'b0, "R13", "early result", 64'(res_valid), 64'd0);
    @(negedge clk);
    check(res_valid == 1'b1, "R13", "latency", 64'(res_valid), 64'd1);
    check(observed() == e, req, $sformatf("addr %h kind %0d pcie %0d wr %0d dbg %0d", a, k, pc, wr, dbg),
          64'(observed()), 64'(e));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] ea, eb, ec;
    mem_top   = 41'h40_0000_0000;
    mem_base  = {16'h0010, 16'hFFF0, 16'h0180, 16'h0100};
    mem_limit = {16'h000F, 16'hFFFF, 16'h02FF, 16'h01FF};
    io_base   = {4'h8, 4'hF, 4'h2, 4'h1};
    io_limit  = {4'h7, 4'hF, 4'h3, 4'h2};
    for (int r = 0; r < 16; r++) leg_attr[2*r +: 2] = 2'(r % 4);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0, "R13", "reset res_valid", 64'(res_valid), 64'd0);
    check(req_ready == 1'b1, "R13", "reset req_ready", 64'(req_ready), 64'd1);

    // Sweep: every pattern, kind, side, direction and debug setting
    for (int i = 0; i < 32; i++)
      for (int k = 0; k < 4; k++)
        for (int m = 0; m < 8; m++)
          send(pattern(i), 2'(k), m[0], m[1], m[2],
               tag_of(model(pattern(i), 2'(k), m[0], m[1], m[2]), 2'(k), m[0]));

    // Directed cases
    send(64'h10_0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, "R1");
    send(64'hF_FFF0_0000, 2'd0, 1'b0, 1'b0, 1'b0, "R1");
    send(64'h100_1000_0000, 2'd0, 1'b0, 1'b0, 1'b1, "R12");
    send(64'h100_1000_0000, 2'd0, 1'b1, 1'b0, 1'b1, "R12");
    send(64'hFFFF_0000_0000_1000, 2'd1, 1'b0, 1'b1, 1'b0, "R3");
    send(64'hFFFF_FFFF_0000_2000, 2'd1, 1'b1, 1'b0, 1'b0, "R4");
    send(64'h0FF0_0000, 2'd2, 1'b0, 1'b0, 1'b0, "R5");
    send(64'h1000_0000, 2'd2, 1'b0, 1'b0, 1'b0, "R5");
    send(64'hC_4000, 2'd0, 1'b0, 1'b1, 1'b0, "R6");
    send(64'hC_8000, 2'd0, 1'b0, 1'b0, 1'b0, "R6");
    send(64'hC_0000, 2'd0, 1'b0, 1'b0, 1'b0, "R7");
    send(64'h1800_0000, 2'd0, 1'b1, 1'b1, 1'b0, "R9");
    send(64'h3000, 2'd1, 1'b0, 1'b0, 1'b0, "R8");

    // Abort outranks a window that covers the legacy area
    mem_base[3] = 16'h0000; mem_limit[3] = 16'h0000;
    send(64'hC_4000, 2'd0, 1'b0, 1'b1, 1'b0, "R11");
    send(64'hC_4000, 2'd0, 1'b0, 1'b0, 1'b0, "R11");
    send(64'hF_C000, 2'd0, 1'b1, 1'b1, 1'b0, "R7");
    // Error outranks abort when the top drops into the legacy area
    mem_top = 41'hC_0000;
    send(64'hC_4000, 2'd0, 1'b1, 1'b1, 1'b0, "R11");
    send(64'hC_4000, 2'd0, 1'b0, 1'b1, 1'b0, "R11");
    mem_top = 41'h40_0000_0000;
    mem_base[3] = 16'h0010; mem_limit[3] = 16'h000F;

    // Back-pressure and ordering
    ea = model(64'h1000_0000, 2'd0, 1'b0, 1'b0, 1'b0);
    eb = model(64'h2_0000, 2'd1, 1'b1, 1'b0, 1'b0);
    ec = model(64'h0123_4000, 2'd2, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1; req_addr = 64'h1000_0000; req_kind = 2'd0; req_from_pcie = 1'b0;
    req_write = 1'b0; req_debug = 1'b0;
    @(negedge clk);
    req_addr = 64'h2_0000; req_kind = 2'd1; req_from_pcie = 1'b1;
    @(negedge clk);
    req_addr = 64'h0123_4000; req_kind = 2'd2; req_from_pcie = 1'b0;
    check(req_ready == 1'b0, "R13", "full stall", 64'(req_ready), 64'd0);
    for (int c = 0; c < 3; c++) begin
      check(res_valid && observed() == ea, "R13", "held first", 64'(observed()), 64'(ea));
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid && observed() == eb, "R13", "second in order", 64'(observed()), 64'(eb));
    @(negedge clk);
    check(res_valid && observed() == ec, "R13", "third in order", 64'(observed()), 64'(ec));
    @(negedge clk);
    check(res_valid == 1'b0, "R13", "drained", 64'(res_valid), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule